// File: doc/BRIEF.md
# Logarithmic-Depth Leading Zero Counter (64-bit)

This block reports how many zero bits precede the most significant set bit of a 64-bit word, counting down from bit 63. It does not scan the bits in priority order. Instead it reduces the word through a balanced binary tree of six merge levels. Every tree node holds two things: a flag that says its span of bits is entirely zero, and a partial count for that span. Each merge level pairs neighbouring nodes and settles exactly one more bit of the count, so the logic depth grows with the logarithm of the width.

The result is registered once at the output, so it appears on the first rising clock edge after the word is presented. A separate flag reports an input word with no set bit at all. In that case the count carries no meaning and is driven to zero. Typical uses are normalisation shifts in arithmetic datapaths and the front end of a priority search.

Top module: `lzc64_tree`

## Requirements
- R1: For a nonzero input, `lead_cnt_o` equals 63 minus the index of the highest set bit of `data_i`.
- R2: `all_zero_o` is 1 exactly when every bit of `data_i` was 0, and 0 otherwise.
- R3: Whenever `all_zero_o` is 1, `lead_cnt_o` is 0.
- R4: When bit 63 of `data_i` is set, `lead_cnt_o` is 0, whatever the lower 63 bits hold.
- R5: Bits below the highest set bit have no effect on `lead_cnt_o`. Words that share their highest set bit give the same count.
- R6: While `rst_n` is low, `lead_cnt_o` is 0 and `all_zero_o` is 0.
- R7: Both outputs reflect the `data_i` value sampled at the previous rising edge of `clk`, giving one cycle of latency. A `data_i` value that is held across an edge leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_i | input | 64 | Word whose leading zeros are counted |
| lead_cnt_o | output | 6 | Registered leading zero count |
| all_zero_o | output | 1 | Registered flag: the sampled word had no set bit |

## Verification
The clocked properties assume that `data_i` is two-state and settled at every rising edge. They also assume that the first edge after reset has loaded the output register before any check relates the outputs to past inputs. For that reason they stay silent until one edge after release. The stimulus changes `data_i` only at falling edges and uses only defined 0/1 values. It covers every single-bit word, the zero word, the all-ones word, words with bit 63 set, and random words shifted so that the highest set bit falls at many different positions.

// File: rtl/lzc64_tree.sv
module lzc64_tree #(
  parameter int LEVELS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       data_i,
  output logic [LEVELS-1:0] lead_cnt_o,
  output logic              all_zero_o
);
  localparam int W = 1 << LEVELS;

  for (genvar k = 0; k <= LEVELS; k++) begin : lvl
    localparam int N = W >> k;
    logic [N-1:0]      z;
    logic [LEVELS-1:0] c [N];
    if (k == 0) begin : g_leaf
      assign z = ~data_i[W-1:0];
      for (genvar i = 0; i < N; i++) begin : g_n
        assign c[i] = '0;
      end
    end else begin : g_merge
      for (genvar i = 0; i < N; i++) begin : g_n
        logic              hi_z;
        logic [LEVELS-1:0] pick;
        assign hi_z  = lvl[k-1].z[2*i+1];
        assign pick  = hi_z ? lvl[k-1].c[2*i] : lvl[k-1].c[2*i+1];
        assign z[i]  = hi_z & lvl[k-1].z[2*i];
        always_comb begin
          c[i]      = pick;
          c[i][k-1] = hi_z;
        end
      end
    end
  end

  logic root_z;
  assign root_z = lvl[LEVELS].z[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_cnt_o <= '0;
      all_zero_o <= 1'b0;
    end else begin
      lead_cnt_o <= root_z ? '0 : lvl[LEVELS].c[0];
      all_zero_o <= root_z;
    end
  end

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  p_cnt_msb_r1: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    !all_zero_o |-> (($past(data_i) >> (6'd63 - lead_cnt_o)) == 64'd1));
  p_flag_match_r2: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    all_zero_o == ($past(data_i) == 64'd0));
  p_cnt_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    all_zero_o |-> (lead_cnt_o == '0));
  p_top_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_i[63] |=> (lead_cnt_o == '0 && !all_zero_o));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    $stable(data_i) |=> ($stable(lead_cnt_o) && $stable(all_zero_o)));
  always_comb begin
    if (!rst_n) a_reset_r6: assert (lead_cnt_o == '0 && !all_zero_o);
  end
endmodule

// File: tb/lzc64_tree_tb.sv
module lzc64_tree_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] data_i = '0;
  logic [5:0]  lead_cnt_o;
  logic        all_zero_o;
  int          n_run = 0;
  int          n_fail = 0;
  logic [63:0] q_word [$];
  string       q_tag [$];

  always #5 clk = ~clk;

  lzc64_tree dut_i (.clk(clk), .rst_n(rst_n), .data_i(data_i),
                    .lead_cnt_o(lead_cnt_o), .all_zero_o(all_zero_o));

  function automatic int scan_lz(logic [63:0] v);
    for (int b = 63; b >= 0; b--) if (v[b]) return 63 - b;
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_head();
    logic [63:0] w;
    string t;
    if (q_word.size() == 0) return;
    w = q_word.pop_front();
    t = q_tag.pop_front();
    check({t, " count"}, lead_cnt_o, scan_lz(w));
    check(w == 0 ? "R2 flag" : {t, " flag"}, all_zero_o, w == 0);
  endtask

  task automatic apply(logic [63:0] w, string tag);
    @(negedge clk);
    compare_head();
    data_i = w;
    q_word.push_back(w);
    q_tag.push_back(tag);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    data_i = 64'hFFFF_0000_1234_5678;
    repeat (3) @(negedge clk);
    check("R6 reset count", lead_cnt_o, 0);
    check("R6 reset flag", all_zero_o, 0);
    rst_n = 1'b1;
    apply(64'd0, "R3");
    for (int b = 0; b < 64; b++) apply(64'd1 << b, b == 63 ? "R4" : "R1");
    apply('1, "R4");
    apply(64'h8000_0000_0000_0001, "R4");
    apply(64'd0, "R3");
    for (int b = 0; b < 64; b++) begin
      apply((64'd1 << b) | ({$urandom, $urandom} & ((64'd1 << b) - 64'd1)), "R5");
    end
    for (int n = 0; n < 300; n++) apply({$urandom, $urandom} >> ($urandom % 64), "R1");
    apply(64'h0000_0400_0000_0000, "R7");
    @(negedge clk);
    compare_head();
    check("R7 held count", lead_cnt_o, 21);
    @(negedge clk);
    check("R7 held again", lead_cnt_o, 21);
    check("R7 held flag", all_zero_o, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule